// File: doc/BRIEF.md
# Vector Doubleword Multiply-Sum Unit

This execution unit takes three vector operands A, B and C, each `2*DW_W` bits wide (128 bits by default). It treats each operand as two unsigned doublewords. It multiplies the matching doublewords of A and B to form two full-width products. It then adds both products to C. A 6-bit extended opcode picks one of two results:

- **Modulo sum** keeps the low `2*DW_W` bits of that total.
- **Carry-out** returns only the two bits that spill past the top of the vector. These are computed by a low-half sum followed by a high-half sum.

Operations enter through a valid/ready handshake and pass through a fixed two-stage pipeline. Stage 1 registers the two products. Stage 2 performs the additions and holds the result until the consumer accepts it.

Every accepted operation produces exactly one output beat. The beat carries one of three outcomes:

- a result write (`res_wr`);
- a vector-unit-unavailable trap, raised when the unit enable was low at issue;
- an illegal-operation trap, raised when the extended opcode is not one of the two supported codes.

A trap beat carries no result.

The pipeline control is an occupancy state machine with four states:

- `PL_EMPTY`: both stages free.
- `PL_HEAD`: only stage 1 occupied.
- `PL_TAIL`: only stage 2 occupied.
- `PL_BOTH`: both stages occupied.

Its named transitions are:

- `FILL`: EMPTY→HEAD.
- `ADVANCE`: HEAD→TAIL, with no new input.
- `STREAM`: HEAD→BOTH, or TAIL→HEAD when the output drains while an input enters.
- `STACK`: TAIL→BOTH, when an input enters while the output stalls.
- `DRAIN`: TAIL→EMPTY.
- `RELEASE`: BOTH→TAIL, when the output drains and no input enters.
- `HOLD`: any state stays where it is.

Top module: `vdw_msum_unit`

## Requirements
- R1: After reset `out_valid`, `res_wr`, `trap_unavail` and `trap_illegal` are 0 and `in_ready` is 1.
- R2: Doubleword 0 of a vector is bits [2*DW_W-1:DW_W] and doubleword 1 is bits [DW_W-1:0]. Products pair only same-index doublewords: A.dw0*B.dw0 and A.dw1*B.dw1.
- R3: With `vec_en`=1 and `ext_op`=35, the beat has `res_wr`=1 and `result` = (A.dw0*B.dw0 + A.dw1*B.dw1 + C) mod 2^(2*DW_W).
- R4: With `vec_en`=1 and `ext_op`=23, the beat has `res_wr`=1. `result` doubleword 1 holds bits [2*DW_W+1:2*DW_W] of the unbounded sum of R3, zero-extended. Doubleword 0 is zero.
- R5: In carry mode, all-ones A, B and C give a carry result of exactly 2. No carry result ever exceeds 2.
- R6: With `vec_en`=0 at issue, whatever the opcode, the beat has `trap_unavail`=1, `res_wr`=0, `trap_illegal`=0 and `result`=0.
- R7: With `vec_en`=1 and `ext_op` other than 35 or 23, the beat has `trap_illegal`=1, `res_wr`=0 and `result`=0.
- R8: An accepted operation presents `out_valid` two clock edges after acceptance when `out_ready` stays high. The unit accepts one operation per cycle in that case.
- R9: While `out_valid`=1 and `out_ready`=0, the output beat stays unchanged. `in_ready` is 0 only when both stages are full and the output stalls. Beats leave in issue order.
- R10: Whenever `out_valid`=1, exactly one of `res_wr`, `trap_unavail`, `trap_illegal` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| ext_op | input | 6 | Extended opcode (35 modulo sum, 23 carry-out) |
| vec_en | input | 1 | Vector unit enabled at issue |
| vec_a | input | 2*DW_W | Operand A |
| vec_b | input | 2*DW_W | Operand B |
| vec_c | input | 2*DW_W | Addend C |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer accepts the beat |
| result | output | 2*DW_W | Result vector, zero on trap beats |
| res_wr | output | 1 | Beat writes a result |
| trap_unavail | output | 1 | Vector-unavailable exception |
| trap_illegal | output | 1 | Illegal-operation exception |

## Verification
Assertions check on every cycle that a beat has exactly one outcome and that trap beats carry a zero result. They also check that a stalled beat is held unchanged, that `in_ready` falls only under a full, stalled pipeline, and that the unit is idle once reset releases.

The arithmetic can only be shown by the bench's scenarios, which run a reduced `DW_W`=4 configuration. These cover the modulo values and the carry values with their 0..2 range and all-ones corner, plus doubleword pairing and opcode decoding over all 64 codes. The two-edge latency, back-to-back throughput and in-order delivery under random backpressure are also shown only by the bench.

// File: rtl/vdw_msum_pkg.sv
package vdw_msum_pkg;
    localparam int XOP_W = 6;
    localparam logic [XOP_W-1:0] XOP_SUM_MOD   = 6'd35;
    localparam logic [XOP_W-1:0] XOP_SUM_CARRY = 6'd23;

    // Operation kind carried down the pipeline
    typedef enum logic [1:0] {
        K_MOD    = 2'd0,
        K_CARRY  = 2'd1,
        K_NOUNIT = 2'd2,
        K_BADOP  = 2'd3
    } op_kind_e;

    // Pipeline occupancy
    typedef enum logic [1:0] {
        PL_EMPTY = 2'd0,
        PL_HEAD  = 2'd1,
        PL_TAIL  = 2'd2,
        PL_BOTH  = 2'd3
    } pipe_state_e;
endpackage

// File: rtl/vdw_msum_decode.sv
module vdw_msum_decode
    import vdw_msum_pkg::*;
(
    input  logic [XOP_W-1:0] xop,
    input  logic             unit_en,
    output op_kind_e         kind
);
    // Disabled unit wins over an unknown opcode
    always_comb begin
        if (!unit_en) begin
            kind = K_NOUNIT;
        end else begin
            unique case (xop)
                XOP_SUM_MOD:   kind = K_MOD;
                XOP_SUM_CARRY: kind = K_CARRY;
                default:       kind = K_BADOP;
            endcase
        end
    end
endmodule

// File: rtl/vdw_msum_ctrl.sv
module vdw_msum_ctrl
    import vdw_msum_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic s1_load,
    output logic s2_load
);
    pipe_state_e st_q, st_nx;
    logic        take, give;

    assign take = in_valid && in_ready;
    assign give = out_valid && out_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PL_EMPTY;
        end else begin
            st_q <= st_nx;
        end
    end

    // Transitions
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            PL_EMPTY: begin
                if (take) st_nx = PL_HEAD;                 // FILL
            end
            PL_HEAD: begin
                if (take) st_nx = PL_BOTH;                 // STREAM
                else      st_nx = PL_TAIL;                 // ADVANCE
            end
            PL_TAIL: begin
                if (take && give)       st_nx = PL_HEAD;   // STREAM
                else if (take)          st_nx = PL_BOTH;   // STACK
                else if (give)          st_nx = PL_EMPTY;  // DRAIN
                else                    st_nx = PL_TAIL;   // HOLD
            end
            PL_BOTH: begin
                if (give && !take)      st_nx = PL_TAIL;   // RELEASE
                else                    st_nx = PL_BOTH;   // HOLD / STREAM
            end
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b1;
        out_valid = 1'b0;
        s2_load   = 1'b0;
        unique case (st_q)
            PL_EMPTY: begin
                in_ready = 1'b1;
            end
            PL_HEAD: begin
                s2_load  = 1'b1;
            end
            PL_TAIL: begin
                out_valid = 1'b1;
            end
            PL_BOTH: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
                s2_load   = out_ready;
            end
        endcase
        s1_load = in_valid && in_ready;
    end
endmodule

// File: rtl/vdw_msum_mul.sv
module vdw_msum_mul
    import vdw_msum_pkg::*;
#(
    parameter  int DW_W  = 64,
    localparam int VEC_W = 2 * DW_W,
    localparam int LANES = 2
) (
    input  logic                        clk,
    input  logic                        load,
    input  logic [VEC_W-1:0]            a,
    input  logic [VEC_W-1:0]            b,
    input  logic [VEC_W-1:0]            c,
    input  op_kind_e                    kind_in,
    output logic [LANES-1:0][VEC_W-1:0] prod_q,
    output logic [VEC_W-1:0]            c_q,
    output op_kind_e                    kind_q
);
    // Lane l multiplies doubleword l; doubleword 0 is the upper half
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [DW_W-1:0]  a_dw, b_dw;
        logic [VEC_W-1:0] prod_d;
        assign a_dw   = a[VEC_W-1-l*DW_W -: DW_W];
        assign b_dw   = b[VEC_W-1-l*DW_W -: DW_W];
        assign prod_d = VEC_W'(a_dw) * VEC_W'(b_dw);
        always_ff @(posedge clk) begin
            if (load) prod_q[l] <= prod_d;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            c_q    <= c;
            kind_q <= kind_in;
        end
    end
endmodule

// File: rtl/vdw_msum_sum.sv
module vdw_msum_sum
    import vdw_msum_pkg::*;
#(
    parameter  int DW_W  = 64,
    localparam int VEC_W = 2 * DW_W,
    localparam int HW_W  = DW_W + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [1:0][VEC_W-1:0] prod,
    input  logic [VEC_W-1:0]      c,
    input  op_kind_e              kind,
    output logic [VEC_W-1:0]      res_q,
    output logic                  wr_q,
    output logic                  unav_q,
    output logic                  ill_q
);
    logic [VEC_W-1:0] mod_sum;
    logic [HW_W-1:0]  lo_sum, hi_sum;
    logic [VEC_W-1:0] res_d;

    // Wrapping sum of both products and the addend
    assign mod_sum = prod[0] + prod[1] + c;

    // Split carry path: low halves first, their carry feeds the high halves
    assign lo_sum = HW_W'(prod[0][DW_W-1:0]) + HW_W'(prod[1][DW_W-1:0])
                  + HW_W'(c[DW_W-1:0]);
    assign hi_sum = HW_W'(prod[0][VEC_W-1:DW_W]) + HW_W'(prod[1][VEC_W-1:DW_W])
                  + HW_W'(c[VEC_W-1:DW_W]) + HW_W'(lo_sum >> DW_W);

    always_comb begin
        unique case (kind)
            K_MOD:   res_d = mod_sum;
            K_CARRY: res_d = VEC_W'(hi_sum >> DW_W);
            default: res_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (load) res_q <= res_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            unav_q <= 1'b0;
            ill_q  <= 1'b0;
        end else if (load) begin
            wr_q   <= (kind == K_MOD) || (kind == K_CARRY);
            unav_q <= (kind == K_NOUNIT);
            ill_q  <= (kind == K_BADOP);
        end
    end
endmodule

// File: rtl/vdw_msum_unit.sv
module vdw_msum_unit
    import vdw_msum_pkg::*;
#(
    parameter  int DW_W  = 64,
    localparam int VEC_W = 2 * DW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [XOP_W-1:0] ext_op,
    input  logic             vec_en,
    input  logic [VEC_W-1:0] vec_a,
    input  logic [VEC_W-1:0] vec_b,
    input  logic [VEC_W-1:0] vec_c,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] result,
    output logic             res_wr,
    output logic             trap_unavail,
    output logic             trap_illegal
);
    op_kind_e              kind_d, kind_s1;
    logic                  s1_load, s2_load;
    logic [1:0][VEC_W-1:0] prod_s1;
    logic [VEC_W-1:0]      c_s1;
    logic [VEC_W-1:0]      res_s2;
    logic                  wr_s2, unav_s2, ill_s2;

    vdw_msum_decode u_dec (
        .xop     (ext_op),
        .unit_en (vec_en),
        .kind    (kind_d)
    );

    vdw_msum_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .s1_load   (s1_load),
        .s2_load   (s2_load)
    );

    vdw_msum_mul #(.DW_W(DW_W)) u_mul (
        .clk     (clk),
        .load    (s1_load),
        .a       (vec_a),
        .b       (vec_b),
        .c       (vec_c),
        .kind_in (kind_d),
        .prod_q  (prod_s1),
        .c_q     (c_s1),
        .kind_q  (kind_s1)
    );

    vdw_msum_sum #(.DW_W(DW_W)) u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (s2_load),
        .prod   (prod_s1),
        .c      (c_s1),
        .kind   (kind_s1),
        .res_q  (res_s2),
        .wr_q   (wr_s2),
        .unav_q (unav_s2),
        .ill_q  (ill_s2)
    );

    assign result       = res_s2;
    assign res_wr       = out_valid && wr_s2;
    assign trap_unavail = out_valid && unav_s2;
    assign trap_illegal = out_valid && ill_s2;
endmodule

// File: rtl/vdw_msum_unit_chk.sv
module vdw_msum_unit_chk #(
    parameter  int DW_W  = 64,
    localparam int VEC_W = 2 * DW_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [VEC_W-1:0] result,
    input logic             res_wr,
    input logic             trap_unavail,
    input logic             trap_illegal
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid && in_ready); // R1

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones({res_wr, trap_unavail, trap_illegal}) == 1); // R10

    AST_TRAP_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !res_wr |-> result == '0); // R6

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(result) && $stable(res_wr)
            && $stable(trap_unavail) && $stable(trap_illegal)); // R9

    AST_READY_ONLY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid && !out_ready); // R9
endmodule

bind vdw_msum_unit vdw_msum_unit_chk #(.DW_W(DW_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .result       (result),
    .res_wr       (res_wr),
    .trap_unavail (trap_unavail),
    .trap_illegal (trap_illegal)
);

// File: tb/vdw_msum_unit_tb.sv
module vdw_msum_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 4;
    localparam int VW = 2 * DW;

    typedef struct packed {
        logic [VW-1:0] res;
        logic          wr;
        logic          un;
        logic          il;
        logic [3:0]    tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [5:0]    ext_op = '0;
    logic          vec_en = 1'b0;
    logic [VW-1:0] vec_a = '0, vec_b = '0, vec_c = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [VW-1:0] result;
    logic          res_wr, trap_unavail, trap_illegal;

    int   n_chk = 0, n_bad = 0;
    int   cyc = 0, take_cyc = 0, pop_cyc = 0;
    int   rdy_mode = 0;  // 0 always ready, 1 random, 2 never
    bit   done = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vdw_msum_unit #(.DW_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .ext_op(ext_op), .vec_en(vec_en), .vec_a(vec_a), .vec_b(vec_b),
        .vec_c(vec_c), .out_valid(out_valid), .out_ready(out_ready),
        .result(result), .res_wr(res_wr), .trap_unavail(trap_unavail),
        .trap_illegal(trap_illegal)
    );

    function automatic string req_name(logic [3:0] t);
        case (t)
            4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
            4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
            4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input bit ok, input logic [3:0] t, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req_name(t), act, exp);
        end
    endtask

    // Reference model from the requirements
    function automatic exp_t ref_out(logic [VW-1:0] a, logic [VW-1:0] b,
                                     logic [VW-1:0] c, logic [5:0] op, logic en);
        exp_t e;
        int full;
        e = '0;
        full = int'(a[VW-1:DW]) * int'(b[VW-1:DW]) + int'(a[DW-1:0]) * int'(b[DW-1:0]) + int'(c);
        if (!en) begin
            e.un = 1'b1; e.tag = 4'd6;
        end else if (op == 6'd35) begin
            e.wr = 1'b1; e.res = VW'(full); e.tag = 4'd3;
        end else if (op == 6'd23) begin
            e.wr = 1'b1; e.res = VW'(full >> VW);
            e.tag = (a == '1 && b == '1 && c == '1) ? 4'd5 : 4'd4;
        end else begin
            e.il = 1'b1; e.tag = 4'd7;
        end
        return e;
    endfunction

    task automatic step(input logic v, input logic [VW-1:0] a, input logic [VW-1:0] b,
                        input logic [VW-1:0] c, input logic [5:0] op, input logic en,
                        output bit took);
        exp_t e;
        @(negedge clk);
        cyc++;
        in_valid = v; vec_a = a; vec_b = b; vec_c = c; ext_op = op; vec_en = en;
        out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : ($urandom % 4 != 0);
        #1;
        if (out_valid && out_ready) begin
            if (q.size() == 0) begin
                check(0, 4'd9, 1, 0);
            end else begin
                e = q.pop_front();
                check({result, res_wr, trap_unavail, trap_illegal} == {e.res, e.wr, e.un, e.il},
                      e.tag, {result, res_wr, trap_unavail, trap_illegal},
                      {e.res, e.wr, e.un, e.il});
                if (e.tag == 4'd4 || e.tag == 4'd5)
                    check(result <= 2, 4'd5, result, 2);  // R5 range
            end
            pop_cyc = cyc;
        end
        took = v && in_ready;
        if (took) begin
            q.push_back(ref_out(a, b, c, op, en));
            take_cyc = cyc;
        end
    endtask

    task automatic issue(input logic [VW-1:0] a, input logic [VW-1:0] b,
                         input logic [VW-1:0] c, input logic [5:0] op, input logic en);
        bit took;
        took = 0;
        while (!took) step(1'b1, a, b, c, op, en, took);
        if (rdy_mode == 1 && $urandom % 8 == 0) step(1'b0, '0, '0, '0, '0, 1'b0, took);
    endtask

    task automatic drain();
        bit took;
        int saved;
        saved = rdy_mode;
        rdy_mode = 0;
        for (int i = 0; i < 8; i++) step(1'b0, '0, '0, '0, '0, 1'b0, took);
        check(q.size() == 0 && !out_valid, 4'd9, q.size(), 0);
        rdy_mode = saved;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit took;
        logic [VW-1:0] r0, r1;
        int n_take;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        check(!out_valid && !res_wr && !trap_unavail && !trap_illegal && in_ready, 4'd1,
              {out_valid, res_wr, trap_unavail, trap_illegal, in_ready}, 1);

        // R2 doubleword pairing and position
        issue(8'hF0, 8'h0F, 8'h00, 6'd35, 1'b1);  // cross pairing would give 225
        issue(8'hF0, 8'h10, 8'h00, 6'd35, 1'b1);  // 15
        issue(8'hFF, 8'hFF, 8'hFF, 6'd23, 1'b1);  // R5 corner -> 2
        issue(8'hFF, 8'hFF, 8'hFF, 6'd35, 1'b1);
        issue(8'h00, 8'h00, 8'h00, 6'd23, 1'b1);
        drain();

        // R8 latency and throughput
        rdy_mode = 0;
        step(1'b1, 8'h23, 8'h45, 8'h67, 6'd35, 1'b1, took);
        step(1'b0, '0, '0, '0, '0, 1'b0, took);
        check(!out_valid, 4'd8, out_valid, 0);
        step(1'b0, '0, '0, '0, '0, 1'b0, took);
        check(pop_cyc - take_cyc == 2, 4'd8, pop_cyc - take_cyc, 2);
        n_take = 0;
        for (int i = 0; i < 10; i++) begin
            step(1'b1, VW'(i * 29), VW'(i * 51), VW'(i), (i % 2) ? 6'd23 : 6'd35, 1'b1, took);
            if (took) n_take++;
        end
        check(n_take == 10, 4'd8, n_take, 10);
        drain();

        // R9 full pipeline stall
        rdy_mode = 2;
        step(1'b1, 8'h11, 8'h22, 8'h33, 6'd35, 1'b1, took);
        step(1'b1, 8'h44, 8'h55, 8'h66, 6'd23, 1'b1, took);
        step(1'b1, 8'h77, 8'h88, 8'h99, 6'd35, 1'b1, took);
        check(!took && !in_ready, 4'd9, in_ready, 0);
        r0 = result;
        step(1'b1, 8'h77, 8'h88, 8'h99, 6'd35, 1'b1, took);
        r1 = result;
        check(r0 == r1 && out_valid, 4'd9, r1, r0);
        rdy_mode = 0;
        step(1'b1, 8'h77, 8'h88, 8'h99, 6'd35, 1'b1, took);
        check(took, 4'd9, took, 1);
        drain();

        // R6 / R7 every opcode, enabled and disabled
        rdy_mode = 1;
        for (int op = 0; op < 64; op++) begin
            issue(VW'(op * 3), VW'(op * 7 + 1), VW'(op), 6'(op), 1'b1);
            issue(VW'(op * 5), VW'(op + 9), VW'(op * 2), 6'(op), 1'b0);
        end
        drain();

        // R3 / R4 near-exhaustive sweep under random backpressure
        for (int ai = 0; ai < 256; ai++) begin
            for (int j = 0; j < 16; j++) begin
                logic [VW-1:0] bv, cv;
                bv = (j == 15) ? 8'hFF : VW'(j * 53 + ai);
                cv = VW'(ai * 7 + j * 29);
                issue(VW'(ai), bv, cv, 6'd35, 1'b1);
                issue(VW'(ai), bv, cv, 6'd23, 1'b1);
            end
        end
        drain();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule